// File: doc/BRIEF.md
# Serial Register-Access Host Port

This block is a slave serial port through which a host controller reads and writes a bank of sixteen 8-bit registers belonging to a line transceiver. The host drives three signals: chip select (`cs_n`), serial clock (`sclk`) and serial data in (`sdi`). The block returns serial data on `sdo`. All three host inputs are synchronised into the system clock `clk` and their edges are detected there. The host can therefore run its clock with no relation to the system clock, as long as each half period of `sclk` lasts at least four `clk` cycles.

A transaction opens when `cs_n` falls. The host first shifts in one command byte. Data bytes follow: one byte, or, with the burst flag set, a run of bytes that walk through the register bank. Location 0 is a status register. It mirrors `status_in` and cannot be written. Locations 1 to 15 are configuration registers, and their contents appear on `regs_flat`.

Each committed write raises `upd_valid` for one `clk` cycle, with the address and the data beside it. This strobe cannot be back-pressured, because a register write has no reason to stall, so it has no ready signal. Consumers must take the strobe in the cycle it is high.

Top module: `hostport`

## Requirements
- R1: After reset, registers 1 to 15 read as zero on `regs_flat`, `upd_valid` is low and `sdo_oe` is low.
- R2: The command byte is shifted least-significant bit first and has these fields:
  - bit 0 is the direction, where 1 means read and 0 means write.
  - bits 4:1 are the register address.
  - bits 6:5 are reserved.
  - bit 7 is the burst flag.
- R3: Input bits are captured on rising edges of `sclk`. A write data byte is committed only after its eighth bit. A committed write gives exactly one single-cycle `upd_valid` pulse, carrying `upd_addr` and `upd_data`. `regs_flat` shows the new value one `clk` cycle after that pulse.
- R4: If `cs_n` rises before a byte is complete, that partial byte is discarded. The next transaction starts again with a command byte.
- R5: During the data phase of a read:
  - `sdo` carries the addressed register LSB first.
  - `sdo` changes only after a falling edge of `sclk`, and each bit is held until the next falling edge.
  - `sdo_oe` is high only in this phase.
- R6: A read of address 0 returns `status_in`. A write to address 0 is ignored and produces no strobe.
- R7: A command whose reserved field is nonzero is ignored. Every further byte is also ignored until `cs_n` goes high.
- R8: In burst mode the address starts at the commanded value and rises by one after every data byte. After 15 it wraps to 0.
- R9: Without burst, only the first data byte is acted on. Any later bytes in the same transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idles low |
| sdi | input | 1 | Host serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High while `sdo` carries read data |
| status_in | input | 8 | Value presented at register address 0 |
| regs_flat | output | 128 | All sixteen registers; register i is in bits 8i+7:8i |
| upd_valid | output | 1 | Single-cycle strobe for each committed write |
| upd_addr | output | 4 | Address of the committed write |
| upd_data | output | 8 | Data of the committed write |

## Verification
A host edge passes through a two-flop synchroniser and then edge detection. The resulting strobe is registered one `clk` cycle later, and `regs_flat` follows one cycle after the strobe. Read data reaches `sdo` about three `clk` cycles after a falling edge of `sclk`.

The bench samples `sdo` just before each rising edge of `sclk`, ten `clk` cycles after the launching falling edge. Strobes are compared by a monitor on falling edges of `clk`, against a queue that the driver fills in order. Register contents are compared only after chip select has closed and the pipeline has settled.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int CMD_W = 8;

  // command byte, first shifted bit is rd
  typedef struct packed {
    logic       burst;
    logic [1:0] rsv;
    logic [3:0] addr;
    logic       rd;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2
  } port_st_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int            W      = 1,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hp_regbank.sv
module hp_regbank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DATA_W-1:0]      status_in,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_stat
        // location 0 only mirrors the status input
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) regs[i] <= '0;
          else        regs[i] <= status_in;
        end
      end else begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                       regs[i] <= '0;
          else if (wr_en && wr_addr == ADDR_W'(i))          regs[i] <= wr_data;
        end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
    end
  endgenerate

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [DATA_W-1:0] upd_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              rise,
  output logic              fall,
  output logic              dropping
);
  localparam int CNT_W = $clog2(DATA_W);

  port_st_t          st;
  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh, nx, tx_sr;
  logic [ADDR_W-1:0] cur_addr;
  logic              is_rd, burst, ld_pend;
  cmd_t              cmd;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign nx       = {sdi_s, sh[DATA_W-1:1]};
  assign cmd      = cmd_t'(nx[CMD_W-1:0]);
  assign rd_addr  = cur_addr;
  assign sdo_oe   = ~cs_s && st == ST_DATA && is_rd;
  assign dropping = st == ST_DROP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_CMD;
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      sh        <= '0;
      tx_sr     <= '0;
      cur_addr  <= '0;
      is_rd     <= 1'b0;
      burst     <= 1'b0;
      ld_pend   <= 1'b0;
      upd_valid <= 1'b0;
      upd_addr  <= '0;
      upd_data  <= '0;
      sdo       <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      upd_valid <= 1'b0;
      ld_pend   <= 1'b0;
      if (ld_pend) tx_sr <= rd_data;
      if (cs_s) begin
        st      <= ST_CMD;
        bit_cnt <= '0;
      end else begin
        if (rise) begin
          sh      <= nx;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(DATA_W-1)) begin
            unique case (st)
              ST_CMD: begin
                if (cmd.rsv != 2'b00) st <= ST_DROP;
                else begin
                  st       <= ST_DATA;
                  cur_addr <= cmd.addr;
                  is_rd    <= cmd.rd;
                  burst    <= cmd.burst;
                  ld_pend  <= cmd.rd;
                end
              end
              ST_DATA: begin
                if (!is_rd && cur_addr != '0) begin
                  upd_valid <= 1'b1;
                  upd_addr  <= cur_addr;
                  upd_data  <= nx;
                end
                if (burst) begin
                  cur_addr <= cur_addr + 1'b1;
                  ld_pend  <= is_rd;
                end else begin
                  st <= ST_DROP;
                end
              end
              default: ;
            endcase
          end
        end
        if (fall && st == ST_DATA && is_rd) begin
          sdo   <= tx_sr[0];
          tx_sr <= tx_sr >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/hostport.sv
module hostport #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2,
  localparam int NREG    = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  input  logic [DATA_W-1:0]      status_in,
  output logic [NREG*DATA_W-1:0] regs_flat,
  output logic                   upd_valid,
  output logic [ADDR_W-1:0]      upd_addr,
  output logic [DATA_W-1:0]      upd_data
);
  logic [2:0]        pins_s;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              rise_w, fall_w, drop_w;

  hp_sync #(.W(3), .STAGES(SYNC_STG), .RST_V(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sclk, sdi}),
    .q    (pins_s)
  );

  hp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .upd_valid(upd_valid),
    .upd_addr (upd_addr),
    .upd_data (upd_data),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rise     (rise_w),
    .fall     (fall_w),
    .dropping (drop_w)
  );

  hp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_in(status_in),
    .wr_en    (upd_valid),
    .wr_addr  (upd_addr),
    .wr_data  (upd_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/hostport_chk.sv
module hostport_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              sdo,
  input logic              rise,
  input logic              fall,
  input logic              dropping
);
  // R3
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

  // R3
  upd_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(rise));

  // R6
  no_status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_addr != '0);

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |=> !upd_valid);
endmodule

bind hostport hostport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_valid(upd_valid),
  .upd_addr (upd_addr),
  .sdo      (sdo),
  .rise     (rise_w),
  .fall     (fall_w),
  .dropping (drop_w)
);

// File: tb/hostport_tb.sv
`timescale 1ns/1ps
module hostport_tb;
  localparam time HALF = 200ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic         sdo, sdo_oe, upd_valid;
  logic [7:0]   status_in = 8'h00;
  logic [127:0] regs_flat;
  logic [3:0]   upd_addr;
  logic [7:0]   upd_data;

  int n_chk = 0, n_fail = 0;
  logic [11:0] exp_q [$];
  logic [7:0]  model [16];
  bit          sdo_bad = 1'b0;
  bit          done = 1'b0;

  always #10ns clk = ~clk;

  hostport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .regs_flat(regs_flat),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic exp_wr(input logic [3:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    model[a] = d;
  endtask

  // monitor: pop and compare each strobe
  always @(negedge clk) begin
    if (rst_n && upd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", {20'd0, upd_addr, upd_data}, 32'd0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({upd_addr, upd_data} == e, "R3 strobe addr/data", {20'd0, upd_addr, upd_data}, {20'd0, e});
      end
    end
  end

  // R5: sdo must not move while sclk is high during a read
  always @(sdo) if (rst_n && sclk && sdo_oe) sdo_bad = 1'b1;

  task automatic shift_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[i];
      #(HALF);
      rx[i] = sdo;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_open;
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic cs_close;
    #(HALF);
    cs_n = 1'b1;
    #(2*HALF);
  endtask

  function automatic logic [7:0] mk_cmd(input bit rd, input logic [3:0] a, input logic [1:0] rsv, input bit bst);
    return {bst, rsv, a, rd};
  endfunction

  task automatic check_regs(input string req);
    for (int i = 1; i < 16; i++)
      chk(regs_flat[i*8 +: 8] == model[i], req, {24'd0, regs_flat[i*8 +: 8]}, {24'd0, model[i]});
  endtask

  initial begin
    #(150000 * 20ns);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    #100ns;
    rst_n = 1'b1;
    #100ns;

    // R1 reset state
    chk(regs_flat == '0, "R1 regs after reset", regs_flat[31:0], 32'd0);
    chk(!upd_valid, "R1 strobe low", {31'd0, upd_valid}, 32'd0);
    chk(!sdo_oe, "R1 sdo_oe low", {31'd0, sdo_oe}, 32'd0);

    // R2 R3 single write
    exp_wr(4'd5, 8'hA5);
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd5, 2'b00, 1'b0), 8, rx);
    chk(!sdo_oe, "R5 sdo_oe low during write", {31'd0, sdo_oe}, 32'd0);
    shift_byte(8'hA5, 8, rx);
    cs_close;
    check_regs("R3 single write");

    // R2 R5 single read
    cs_open;
    shift_byte(mk_cmd(1'b1, 4'd5, 2'b00, 1'b0), 8, rx);
    chk(sdo_oe, "R5 sdo_oe in read", {31'd0, sdo_oe}, 32'd1);
    shift_byte(8'h00, 8, rx);
    cs_close;
    chk(rx == 8'hA5, "R5 read addr 5", {24'd0, rx}, 32'hA5);

    // R6 status read and write ignored
    status_in = 8'h3C;
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd0, 2'b00, 1'b0), 8, rx);
    shift_byte(8'hFF, 8, rx);
    cs_close;
    cs_open;
    shift_byte(mk_cmd(1'b1, 4'd0, 2'b00, 1'b0), 8, rx);
    shift_byte(8'h00, 8, rx);
    cs_close;
    chk(rx == 8'h3C, "R6 status read", {24'd0, rx}, 32'h3C);

    // R7 reserved field nonzero
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd7, 2'b01, 1'b0), 8, rx);
    shift_byte(8'h5A, 8, rx);
    shift_byte(8'h77, 8, rx);
    cs_close;
    check_regs("R7 reserved cmd ignored");

    // R4 partial byte dropped
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd3, 2'b00, 1'b0), 8, rx);
    shift_byte(8'h1F, 5, rx);
    cs_close;
    check_regs("R4 partial byte");

    // R9 second byte ignored without burst
    exp_wr(4'd2, 8'h81);
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd2, 2'b00, 1'b0), 8, rx);
    shift_byte(8'h81, 8, rx);
    shift_byte(8'h42, 8, rx);
    cs_close;
    check_regs("R9 extra byte ignored");

    // R8 burst write wrapping 14,15,0,1
    exp_wr(4'd14, 8'hE1);
    exp_wr(4'd15, 8'hF2);
    exp_wr(4'd1,  8'h13);
    model[0] = 8'h00;
    cs_open;
    shift_byte(mk_cmd(1'b0, 4'd14, 2'b00, 1'b1), 8, rx);
    shift_byte(8'hE1, 8, rx);
    shift_byte(8'hF2, 8, rx);
    shift_byte(8'h99, 8, rx);
    shift_byte(8'h13, 8, rx);
    cs_close;
    check_regs("R8 burst write wrap");

    // R8 burst read 15,0,1
    status_in = 8'hC7;
    cs_open;
    shift_byte(mk_cmd(1'b1, 4'd15, 2'b00, 1'b1), 8, rx);
    shift_byte(8'h00, 8, rx);
    chk(rx == 8'hF2, "R8 burst read addr 15", {24'd0, rx}, 32'hF2);
    shift_byte(8'h00, 8, rx);
    chk(rx == 8'hC7, "R8 burst read wraps to status", {24'd0, rx}, 32'hC7);
    shift_byte(8'h00, 8, rx);
    chk(rx == 8'h13, "R8 burst read addr 1", {24'd0, rx}, 32'h13);
    cs_close;
    chk(!sdo_oe, "R5 sdo_oe low after close", {31'd0, sdo_oe}, 32'd0);

    chk(!sdo_bad, "R5 sdo stable while sclk high", {31'd0, sdo_bad}, 32'd0);
    chk(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule